// File: doc/BRIEF.md
# Chroma Planar Intra Predictor

The block forms a planar intra-prediction block for chroma that is stored as interleaved two-component pairs (Cb, Cr). Before a run, the neighbouring reference samples are written, one pair per write, into a small internal register file. A start pulse then selects a block size of 4, 8 or 16 and begins the run. Predicted rows leave the block from top to bottom over a valid/ready handshake, one whole row per transfer.

Each output sample blends four reference values with weights that depend on its row and column. The two components of a pair are predicted independently, but they share the same weights, so every column weight is used twice across a row. The result is rounded, then shifted by an amount derived at run time from the block size. A one-cycle completion pulse follows the last row.

Top module: `chroma_planar_pred`

## Requirements
- R1: After reset, `out_valid` and `done` are 0 and `out_data` is all zero.
- R2: A write with `ref_we` high stores `ref_wdata` at pair index `ref_addr` (0 to 64). Bits 7:0 are the Cb sample and bits 15:8 are the Cr sample.
- R3: For block size nt, row r and column c, each component is computed as S = (r+1)·P[nt-1] + (nt-1-r)·P[2nt+1+c] + (c+1)·P[3nt+1] + (nt-1-c)·P[2nt-1-r] + nt, using that component of the stored pairs P.
- R4: The output sample is S shifted right by log2(nt)+1 (3, 4 or 5) and narrowed to 8 bits. This stays exact when every reference sample is 255.
- R5: Rows leave in order 0 to nt-1, and `out_row` gives the row number of the row on offer. The left reference index therefore falls as the row number rises.
- R6: In `out_data`, byte 2c holds the Cb result of column c and byte 2c+1 holds its Cr result. Bytes from 2nt up to 31 are zero.
- R7: While `out_valid` is high and `out_ready` is low, the block keeps `out_valid` high and keeps the same row on offer.
- R8: `done` is high for exactly one cycle, in the cycle after the handshake of row nt-1. `out_valid` is low in that cycle.
- R9: A start pulse that arrives while a run is in progress has no effect on that run.
- R10: An `nt_in` value other than 4, 8 or 16 runs as nt = 4.
- R11: While `out_valid` is low, `out_data` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Pulse that begins a run when the block is idle |
| nt_in | input | 5 | Requested block size, sampled with start |
| ref_we | input | 1 | Reference pair write enable |
| ref_addr | input | 7 | Reference pair index |
| ref_wdata | input | 16 | Reference pair value, Cr in the high byte and Cb in the low byte |
| out_valid | output | 1 | A predicted row is on offer |
| out_ready | input | 1 | The consumer accepts the row |
| out_row | output | 4 | Row number of the row on offer |
| out_data | output | 256 | Predicted row, 32 interleaved bytes |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
On every cycle, the bound checker enforces the handshake rules: the valid signal and the row number hold during back-pressure, rows advance one at a time, the completion pulse and where it comes from are checked, the padding bytes and the idle output stay zero, and only legal sizes are latched. The arithmetic itself cannot be checked there. Its correctness (weights, reference indexing per row and column, rounding and shift per size, component separation) shows only in the bench. The bench sweeps every row of every size over several reference patterns and compares each row with a value it computes arithmetically. The same holds for ignoring a start pulse during a stalled run and for mapping an illegal size to 4.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_st_e;

   // Only 8 and 16 are accepted as given; anything else runs as 4.
   function automatic int unsigned legal_nt(input int unsigned n);
      return (n == 8 || n == 16) ? n : 4;
   endfunction

   // Index of the highest set bit plus one: 3, 4 or 5 for 4, 8 or 16.
   function automatic int unsigned bit_len(input int unsigned n);
      int unsigned len;
      len = 0;
      for (int i = 0; i < 32; i++) begin
         if (n[i]) len = i + 1;
      end
      return len;
   endfunction

endpackage

// File: rtl/cpp_ref_store.sv
module cpp_ref_store #(
   parameter int unsigned DEPTH  = 65,
   parameter int unsigned IDX_W  = 7,
   parameter int unsigned PAIR_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [IDX_W-1:0]        addr,
   input  logic [PAIR_W-1:0]       wdata,
   output logic [DEPTH*PAIR_W-1:0] ref_flat
);

   logic [PAIR_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      end else if (we && (32'(addr) < DEPTH)) begin
         mem[addr] <= wdata;
      end
   end

   for (genvar i = 0; i < int'(DEPTH); i++) begin : g_flat
      assign ref_flat[i*PAIR_W +: PAIR_W] = mem[i];
   end

endmodule

// File: rtl/cpp_row_seq.sv
module cpp_row_seq import cpp_pkg::*; #(
   parameter int unsigned NT_W    = 5,
   parameter int unsigned ROW_W   = 4,
   parameter int unsigned IDX_W   = 7,
   parameter int unsigned SHIFT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [NT_W-1:0]    nt_in,
   input  logic               out_ready,
   output logic               busy,
   output logic [NT_W-1:0]    nt_q,
   output logic [SHIFT_W-1:0] shift_q,
   output logic [ROW_W-1:0]   row_q,
   output logic [NT_W-1:0]    w_inc,
   output logic [NT_W-1:0]    w_dec,
   output logic [IDX_W-1:0]   left_idx,
   output logic               done
);

   seq_st_e         st;
   logic [NT_W-1:0] nt_new;
   logic            fire;
   logic            last;

   assign nt_new = NT_W'(legal_nt(32'(nt_in)));
   assign busy   = (st == ST_RUN);
   assign fire   = busy && out_ready;
   assign last   = (NT_W'(row_q) == nt_q - NT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         nt_q     <= NT_W'(4);
         shift_q  <= '0;
         row_q    <= '0;
         w_inc    <= '0;
         w_dec    <= '0;
         left_idx <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (st == ST_IDLE) begin
            if (start) begin
               st       <= ST_RUN;
               nt_q     <= nt_new;
               shift_q  <= SHIFT_W'(bit_len(32'(nt_new)));
               row_q    <= '0;
               w_inc    <= NT_W'(1);
               w_dec    <= nt_new - NT_W'(1);
               left_idx <= IDX_W'(2 * 32'(nt_new) - 1);
            end
         end else if (fire) begin
            if (last) begin
               st   <= ST_IDLE;
               done <= 1'b1;
            end else begin
               row_q    <= row_q + ROW_W'(1);
               w_inc    <= w_inc + NT_W'(1);
               w_dec    <= w_dec - NT_W'(1);
               left_idx <= left_idx - IDX_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/cpp_plane_row.sv
module cpp_plane_row #(
   parameter int unsigned NT_MAX  = 16,
   parameter int unsigned SW      = 8,
   parameter int unsigned DEPTH   = 65,
   parameter int unsigned IDX_W   = 7,
   parameter int unsigned NT_W    = 5,
   parameter int unsigned SHIFT_W = 3
) (
   input  logic [DEPTH*2*SW-1:0]  ref_flat,
   input  logic                   valid,
   input  logic [NT_W-1:0]        nt_q,
   input  logic [SHIFT_W-1:0]     shift_q,
   input  logic [NT_W-1:0]        w_inc,
   input  logic [NT_W-1:0]        w_dec,
   input  logic [IDX_W-1:0]       left_idx,
   output logic [2*NT_MAX*SW-1:0] row_data
);

   localparam int unsigned PAIR_W = 2 * SW;
   localparam int unsigned ACC_W  = 2 * SW;
   localparam int unsigned NT_MIN = 4;

   if ((2 * NT_MAX * ((1 << SW) - 1) + NT_MAX) >= (1 << ACC_W)) begin : g_acc_bad
      $error("accumulator too narrow for NT_MAX and SW");
   end

   logic [IDX_W-1:0]  bl_idx, tr_idx;
   logic [PAIR_W-1:0] bl_p, tr_p, lf_p;

   assign bl_idx = IDX_W'(32'(nt_q) - 1);
   assign tr_idx = IDX_W'(3 * 32'(nt_q) + 1);
   assign bl_p   = ref_flat[bl_idx*PAIR_W +: PAIR_W];
   assign tr_p   = ref_flat[tr_idx*PAIR_W +: PAIR_W];
   assign lf_p   = ref_flat[left_idx*PAIR_W +: PAIR_W];

   for (genvar c = 0; c < int'(NT_MAX); c++) begin : g_col
      logic [IDX_W-1:0]  top_idx;
      logic [PAIR_W-1:0] top_p;
      logic [NT_W-1:0]   w_left;
      logic              active;

      assign top_idx = IDX_W'(2 * 32'(nt_q) + 1 + c);
      assign top_p   = ref_flat[top_idx*PAIR_W +: PAIR_W];
      assign w_left  = NT_W'(32'(nt_q) - 1 - c);

      // Columns below the smallest size are always inside the block.
      if (c < int'(NT_MIN)) begin : g_always
         assign active = valid;
      end else begin : g_gated
         assign active = valid && (32'(nt_q) > c);
      end

      for (genvar k = 0; k < 2; k++) begin : g_comp
         logic [ACC_W-1:0] acc;
         assign acc = ACC_W'(w_inc)  * ACC_W'(bl_p[k*SW +: SW])
                    + ACC_W'(w_dec)  * ACC_W'(top_p[k*SW +: SW])
                    + ACC_W'(c + 1)  * ACC_W'(tr_p[k*SW +: SW])
                    + ACC_W'(w_left) * ACC_W'(lf_p[k*SW +: SW])
                    + ACC_W'(nt_q);
         assign row_data[(2*c+k)*SW +: SW] = active ? SW'(acc >> shift_q) : '0;
      end
   end

endmodule

// File: rtl/chroma_planar_pred.sv
module chroma_planar_pred import cpp_pkg::*; #(
   parameter  int unsigned NT_MAX   = 16,
   parameter  int unsigned SAMPLE_W = 8,
   localparam int unsigned DEPTH    = 4 * NT_MAX + 1,
   localparam int unsigned IDX_W    = $clog2(DEPTH),
   localparam int unsigned NT_W     = $clog2(NT_MAX) + 1,
   localparam int unsigned ROW_W    = $clog2(NT_MAX),
   localparam int unsigned PAIR_W   = 2 * SAMPLE_W,
   localparam int unsigned DATA_W   = 2 * NT_MAX * SAMPLE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NT_W-1:0]   nt_in,
   input  logic              ref_we,
   input  logic [IDX_W-1:0]  ref_addr,
   input  logic [PAIR_W-1:0] ref_wdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ROW_W-1:0]  out_row,
   output logic [DATA_W-1:0] out_data,
   output logic              done
);

   localparam int unsigned SHIFT_W = $clog2(bit_len(NT_MAX) + 1);

   if (NT_MAX != 16) begin : g_nt_bad
      $error("NT_MAX must be 16 to cover sizes 4, 8 and 16");
   end
   if (SAMPLE_W != 8) begin : g_sw_bad
      $error("only 8-bit samples are supported");
   end

   logic [DEPTH*PAIR_W-1:0] ref_flat;
   logic [NT_W-1:0]         nt_q;
   logic [SHIFT_W-1:0]      shift_q;
   logic [NT_W-1:0]         w_inc, w_dec;
   logic [IDX_W-1:0]        left_idx;

   cpp_ref_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PAIR_W(PAIR_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ref_we),
      .addr     (ref_addr),
      .wdata    (ref_wdata),
      .ref_flat (ref_flat)
   );

   cpp_row_seq #(.NT_W(NT_W), .ROW_W(ROW_W), .IDX_W(IDX_W), .SHIFT_W(SHIFT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .nt_in     (nt_in),
      .out_ready (out_ready),
      .busy      (out_valid),
      .nt_q      (nt_q),
      .shift_q   (shift_q),
      .row_q     (out_row),
      .w_inc     (w_inc),
      .w_dec     (w_dec),
      .left_idx  (left_idx),
      .done      (done)
   );

   cpp_plane_row #(.NT_MAX(NT_MAX), .SW(SAMPLE_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
                   .NT_W(NT_W), .SHIFT_W(SHIFT_W)) u_row (
      .ref_flat (ref_flat),
      .valid    (out_valid),
      .nt_q     (nt_q),
      .shift_q  (shift_q),
      .w_inc    (w_inc),
      .w_dec    (w_dec),
      .left_idx (left_idx),
      .row_data (out_data)
   );

endmodule

// File: rtl/cpp_planar_chk.sv
module cpp_planar_chk #(
   parameter int unsigned NT_MAX = 16,
   parameter int unsigned SW     = 8,
   parameter int unsigned NT_W   = 5,
   parameter int unsigned ROW_W  = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   out_valid,
   input logic                   out_ready,
   input logic [ROW_W-1:0]       out_row,
   input logic [2*NT_MAX*SW-1:0] out_data,
   input logic                   done,
   input logic [NT_W-1:0]        nt_q
);

   logic [2*NT_MAX*SW-1:0] pad_mask;

   always_comb begin
      pad_mask = '0;
      for (int b = 0; b < int'(2 * NT_MAX); b++) begin
         if (b >= 2 * int'(nt_q)) pad_mask[b*SW +: SW] = '1;
      end
   end

   // R7
   hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid);

   // R7
   hold_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> $stable(out_row));

   // R5
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready |=> !out_valid || (out_row == $past(out_row) + ROW_W'(1)));

   // R5
   row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (NT_W'(out_row) < nt_q));

   // R8
   done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(out_valid && out_ready));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid);

   // R6
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_data & pad_mask) == '0));

   // R11
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_data == '0));

   // R10
   legal_nt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (nt_q == NT_W'(4) || nt_q == NT_W'(8) || nt_q == NT_W'(16)));

endmodule

bind chroma_planar_pred cpp_planar_chk #(
   .NT_MAX (NT_MAX),
   .SW     (SAMPLE_W),
   .NT_W   (NT_W),
   .ROW_W  (ROW_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_row   (out_row),
   .out_data  (out_data),
   .done      (done),
   .nt_q      (nt_q)
);

// File: tb/chroma_planar_pred_tb.sv
`timescale 1ns/1ps
module chroma_planar_pred_tb;

   localparam int DW = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [4:0]    nt_in = '0;
   logic          ref_we = 1'b0;
   logic [6:0]    ref_addr = '0;
   logic [15:0]   ref_wdata = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [3:0]    out_row;
   logic [DW-1:0] out_data;
   logic          done;

   int checks = 0;
   int errors = 0;
   int cb_m [65];
   int cr_m [65];

   always #2.5 clk = ~clk;

   chroma_planar_pred u_dut (
      .clk (clk), .rst_n (rst_n), .start (start), .nt_in (nt_in),
      .ref_we (ref_we), .ref_addr (ref_addr), .ref_wdata (ref_wdata),
      .out_valid (out_valid), .out_ready (out_ready), .out_row (out_row),
      .out_data (out_data), .done (done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_row(input int nt, input int row);
      logic [DW-1:0] r;
      int sh, a;
      r  = '0;
      sh = (nt == 4) ? 3 : (nt == 8) ? 4 : 5;
      for (int c = 0; c < nt; c++) begin
         a = (row+1)*cb_m[nt-1] + (nt-1-row)*cb_m[2*nt+1+c] + (c+1)*cb_m[3*nt+1]
           + (nt-1-c)*cb_m[2*nt-1-row] + nt;
         r[(2*c)*8 +: 8] = 8'((a >> sh) & 255);
         a = (row+1)*cr_m[nt-1] + (nt-1-row)*cr_m[2*nt+1+c] + (c+1)*cr_m[3*nt+1]
           + (nt-1-c)*cr_m[2*nt-1-row] + nt;
         r[(2*c+1)*8 +: 8] = 8'((a >> sh) & 255);
      end
      return r;
   endfunction

   // R2: Cb in bits 7:0, Cr in bits 15:8, one pair per index
   task automatic load(input int p);
      for (int i = 0; i < 65; i++) begin
         case (p)
            0: begin cb_m[i] = (i*37 + 11) & 255; cr_m[i] = (i*91 + 200) & 255; end
            1: begin cb_m[i] = 255; cr_m[i] = 255; end
            2: begin cb_m[i] = (i % 2) ? 255 : 0; cr_m[i] = (i % 2) ? 0 : 255; end
            default: begin cb_m[i] = (i*4) & 255; cr_m[i] = 255 - ((i*3) & 255); end
         endcase
         @(negedge clk);
         ref_we    = 1'b1;
         ref_addr  = 7'(i);
         ref_wdata = {8'(cr_m[i]), 8'(cb_m[i])};
      end
      @(negedge clk);
      ref_we = 1'b0;
   endtask

   task automatic run(input int nt_req, input int nt_eff, input bit stall,
                      input bit inj, input string tag);
      int rows = 0;
      int cyc  = 0;
      @(negedge clk);
      start = 1'b1;
      nt_in = 5'(nt_req);
      @(negedge clk);
      start = 1'b0;
      while (rows < nt_eff && cyc < 400) begin
         out_ready = stall ? ((cyc % 3) != 2) : 1'b1;
         // R9: a start during a stalled row must not restart the run
         start = inj && (cyc == 2);
         nt_in = 5'd16;
         if (out_valid && out_ready) begin
            chk(out_row == 4'(rows), inj ? "R9" : "R5", "row index", DW'(out_row), DW'(rows));
            chk(out_data == exp_row(nt_eff, rows), tag, "row data", out_data, exp_row(nt_eff, rows));
            rows++;
         end else begin
            chk(out_valid && out_row == 4'(rows), "R7", "row held under stall",
                DW'({out_valid, out_row}), DW'({1'b1, 4'(rows)}));
         end
         cyc++;
         @(negedge clk);
      end
      start     = 1'b0;
      out_ready = 1'b0;
      chk(done == 1'b1, "R8", "done after last row", DW'(done), DW'(1));
      chk(out_valid == 1'b0, "R8", "valid low with done", DW'(out_valid), DW'(0));
      chk(out_data == '0, "R11", "idle data zero", out_data, '0);
      @(negedge clk);
      chk(done == 1'b0, "R8", "done lasts one cycle", DW'(done), DW'(0));
   endtask

   initial begin
      #(5.0 * 200000);
      chk(1'b0, "R1", "watchdog expired", '0, '0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1
      chk(out_valid == 1'b0 && done == 1'b0, "R1", "reset flags", DW'({out_valid, done}), '0);
      chk(out_data == '0, "R1", "reset data", out_data, '0);
      rst_n = 1'b1;
      @(negedge clk);

      load(0);
      run(4, 4, 1'b0, 1'b0, "R6");
      run(8, 8, 1'b1, 1'b0, "R3");
      run(16, 16, 1'b0, 1'b0, "R3");
      load(1);
      run(4, 4, 1'b0, 1'b0, "R4");
      run(8, 8, 1'b0, 1'b0, "R4");
      run(16, 16, 1'b1, 1'b0, "R4");
      load(2);
      run(4, 4, 1'b1, 1'b0, "R2");
      run(8, 8, 1'b0, 1'b0, "R2");
      run(16, 16, 1'b0, 1'b0, "R2");
      load(3);
      run(16, 16, 1'b1, 1'b1, "R3");
      run(8, 8, 1'b1, 1'b1, "R3");
      run(5, 4, 1'b0, 1'b0, "R10");
      run(0, 4, 1'b1, 1'b0, "R10");
      run(31, 4, 1'b0, 1'b0, "R10");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule